// File: doc/BRIEF.md
# SPI Status Flag Unit

This block keeps the three event flags of a byte-wide serial peripheral port and presents them to the CPU as one read-only status byte. The flags are transfer complete, write collision and mode fault. The serial shift engine sits outside the block. It reports two things: whether a transfer is in progress, and a one-cycle pulse when the last of eight serial clocks finishes. The CPU side is a set of address-decode strobes for the status, data and first control register, plus read and write enables.

A flag never clears on its own. Software must first read the status register while the flag is set. A later access then clears it. For transfer complete and write collision that access is any read or write of the data register. For mode fault it is a write to control register 1. A data-register write while a transfer is running is refused through an inhibit output and is recorded as a collision. Mode fault watches the slave-select pin while the port is master. That watch is switched off when the pin is configured as an output.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset, `statusByte` is 8'h00 and `irqReq` is 0.
- R2: The status byte places transfer complete in bit 7, write collision in bit 6 and mode fault in bit 4. Bits 5 and 3..0 always read 0. A write addressed to the status register changes no flag.
- R3: A `xferDone` pulse in one cycle sets bit 7 at the following clock edge.
- R4: Bit 7 clears only by this sequence: a status read taken while bit 7 is 1, then a data-register read or write in a later cycle. A data access with no such read leaves bit 7 at 1.
- R5: A data-register write while `xferActive` is 1 drives `dataWrInhibit` high in the same cycle and sets bit 6 at the next edge. When no transfer is active, `dataWrInhibit` stays 0.
- R6: Write collision never raises `irqReq`. It clears by the same read-then-data-access sequence as R4.
- R7: With `masterEn` at 1, `ssDirOut` at 0 and `ssPinLvl` low, bit 4 sets at the next edge.
- R8: While `ssDirOut` is 1, mode fault does not set, whatever the state of `masterEn` and `ssPinLvl`.
- R9: Bit 4 clears only by this sequence: a status read taken while bit 4 is 1, then a write to control register 1. Data-register accesses do not clear it.
- R10: A set event cancels any clear that is pending for that flag. A clearing access that falls after a set event does not clear the flag. When a set event and a clearing access fall in the same cycle, the flag stays 1.
- R11: `irqReq` equals `irqEn` AND (bit 7 OR bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selStatus | input | 1 | Address decode: status register |
| selData | input | 1 | Address decode: data register |
| selCtrl1 | input | 1 | Address decode: control register 1 |
| rdEn | input | 1 | CPU read enable |
| wrEn | input | 1 | CPU write enable |
| xferActive | input | 1 | Shift engine is mid-transfer |
| xferDone | input | 1 | One-cycle pulse when the eighth serial clock completes |
| masterEn | input | 1 | Port is configured as master |
| ssPinLvl | input | 1 | Level of the slave-select pin |
| ssDirOut | input | 1 | Slave-select pin is configured as an output |
| irqEn | input | 1 | Interrupt enable |
| statusByte | output | 8 | Status register read value |
| irqReq | output | 1 | Interrupt request |
| dataWrInhibit | output | 1 | Drop the current data-register write |

## Verification
Two things can land on the same flag in one cycle: a fresh set event and the access that would complete a pending clear. The bench provokes this in two ways. First, it arms a clear with a status read, raises `xferDone` in the next cycle, and then accesses the data register. Second, it arms a clear and then fires `xferDone` in the same cycle as the data access. In both cases bit 7 must still read 1 afterwards. A further clean read-then-access sequence must then clear it.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int STAT_W    = 8;
  localparam int NUM_FLAGS = 3;
  localparam int IDX_DONE  = 0;
  localparam int IDX_WCOL  = 1;
  localparam int IDX_MODF  = 2;

  typedef struct packed {
    logic statusRead;
    logic dataAccess;
    logic ctrl1Write;
    logic busyWrite;
  } busStrobes_t;
endpackage

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
(
  input  logic        selStatus,
  input  logic        selData,
  input  logic        selCtrl1,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        xferActive,
  output busStrobes_t strobes,
  output logic        dataWrInhibit
);
  logic dataWrite;

  always_comb begin
    dataWrite          = selData & wrEn;
    strobes.statusRead = selStatus & rdEn;
    strobes.dataAccess = selData & (rdEn | wrEn);
    strobes.ctrl1Write = selCtrl1 & wrEn;
    strobes.busyWrite  = dataWrite & xferActive;
    dataWrInhibit      = strobes.busyWrite;
  end

  always_comb begin
    AST_INHIBIT_ONLY_WRITES: assert (!dataWrInhibit || (selData && wrEn)); // R5
  end
endmodule

// File: rtl/spi_flag_dp.sv
module spi_flag_dp
  import spi_flag_pkg::*;
#(
  parameter int DONE_BIT = 7,
  parameter int WCOL_BIT = 6,
  parameter int MODF_BIT = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic              xferDone,
  input  logic              masterEn,
  input  logic              ssPinLvl,
  input  logic              ssDirOut,
  input  logic              irqEn,
  output logic [STAT_W-1:0] statusByte,
  output logic              irqReq
);
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] armedQ;
  logic [NUM_FLAGS-1:0] setEv;
  logic [NUM_FLAGS-1:0] clrAcc;
  logic                 faultCond;

  always_comb begin
    faultCond         = masterEn & ~ssPinLvl & ~ssDirOut;
    setEv[IDX_DONE]   = xferDone;
    setEv[IDX_WCOL]   = strobes.busyWrite;
    setEv[IDX_MODF]   = faultCond;
    clrAcc[IDX_DONE]  = strobes.dataAccess;
    clrAcc[IDX_WCOL]  = strobes.dataAccess;
    clrAcc[IDX_MODF]  = strobes.ctrl1Write;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[g]  <= 1'b0;
        armedQ[g] <= 1'b0;
      end else if (setEv[g]) begin
        flagQ[g]  <= 1'b1;
        armedQ[g] <= 1'b0;
      end else if (armedQ[g] && clrAcc[g]) begin
        flagQ[g]  <= 1'b0;
        armedQ[g] <= 1'b0;
      end else if (strobes.statusRead && flagQ[g]) begin
        armedQ[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    statusByte           = '0;
    statusByte[DONE_BIT] = flagQ[IDX_DONE];
    statusByte[WCOL_BIT] = flagQ[IDX_WCOL];
    statusByte[MODF_BIT] = flagQ[IDX_MODF];
    irqReq               = irqEn & (flagQ[IDX_DONE] | flagQ[IDX_MODF]);
  end

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> statusByte[DONE_BIT]); // R3
  AST_WCOL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busyWrite |=> statusByte[WCOL_BIT]); // R5
  AST_DONE_CLR_BY_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[DONE_BIT]) |-> $past(strobes.dataAccess)); // R4
  AST_MODF_CLR_BY_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[MODF_BIT]) |-> $past(strobes.ctrl1Write)); // R9
  AST_MODF_SUPPRESSED: assert property (@(posedge clk) disable iff (!rstN)
    (ssDirOut && !statusByte[MODF_BIT]) |=> !statusByte[MODF_BIT]); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && strobes.dataAccess) |=> statusByte[DONE_BIT]); // R10
  AST_WCOL_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (!statusByte[DONE_BIT] && !statusByte[MODF_BIT]) |-> !irqReq); // R6
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selStatus,
  input  logic        selData,
  input  logic        selCtrl1,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        xferActive,
  input  logic        xferDone,
  input  logic        masterEn,
  input  logic        ssPinLvl,
  input  logic        ssDirOut,
  input  logic        irqEn,
  output logic [7:0]  statusByte,
  output logic        irqReq,
  output logic        dataWrInhibit
);
  busStrobes_t strobes;

  spi_flag_ctrl ctrl_i (
    .selStatus    (selStatus),
    .selData      (selData),
    .selCtrl1     (selCtrl1),
    .rdEn         (rdEn),
    .wrEn         (wrEn),
    .xferActive   (xferActive),
    .strobes      (strobes),
    .dataWrInhibit(dataWrInhibit)
  );

  spi_flag_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .xferDone  (xferDone),
    .masterEn  (masterEn),
    .ssPinLvl  (ssPinLvl),
    .ssDirOut  (ssDirOut),
    .irqEn     (irqEn),
    .statusByte(statusByte),
    .irqReq    (irqReq)
  );
endmodule

// File: tb/spi_flag_unit_tb.sv
`timescale 1ns/1ps
module spi_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selStatus = 0, selData = 0, selCtrl1 = 0, rdEn = 0, wrEn = 0;
  logic xferActive = 0, xferDone = 0, masterEn = 0, ssPinLvl = 1, ssDirOut = 0, irqEn = 0;
  logic [7:0] statusByte;
  logic irqReq, dataWrInhibit;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .selStatus(selStatus), .selData(selData),
    .selCtrl1(selCtrl1), .rdEn(rdEn), .wrEn(wrEn), .xferActive(xferActive),
    .xferDone(xferDone), .masterEn(masterEn), .ssPinLvl(ssPinLvl),
    .ssDirOut(ssDirOut), .irqEn(irqEn), .statusByte(statusByte),
    .irqReq(irqReq), .dataWrInhibit(dataWrInhibit)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleBus();
    selStatus = 0; selData = 0; selCtrl1 = 0; rdEn = 0; wrEn = 0; xferDone = 0;
  endtask

  // Inputs are applied 1 ns after an edge; the next edge captures them.
  task automatic tick();
    @(posedge clk); #1;
    idleBus();
  endtask

  task automatic statusRd(); selStatus = 1; rdEn = 1; tick(); endtask
  task automatic dataRd();   selData = 1; rdEn = 1; tick(); endtask
  task automatic dataWr();   selData = 1; wrEn = 1; tick(); endtask
  task automatic pulseDone(); xferDone = 1; tick(); endtask

  task automatic tReset();
    check("R1 status", statusByte, 8'h00);
    check("R1 irq", {7'd0, irqReq}, 8'h00);
  endtask

  task automatic tDoneFlag();
    irqEn = 1;
    pulseDone();
    check("R3 done set", statusByte, 8'h80);
    check("R11 irq on done", {7'd0, irqReq}, 8'h01);
    selStatus = 1; wrEn = 1; tick();
    check("R2 status write ignored", statusByte, 8'h80);
    dataRd();
    check("R4 no clear without read", statusByte, 8'h80);
    statusRd();
    check("R4 read alone keeps flag", statusByte, 8'h80);
    dataRd();
    check("R4 cleared", statusByte, 8'h00);
    check("R11 irq drops", {7'd0, irqReq}, 8'h00);
  endtask

  task automatic tCollision();
    xferActive = 1;
    selData = 1; wrEn = 1; #0.5;
    check("R5 inhibit busy write", {7'd0, dataWrInhibit}, 8'h01);
    tick();
    check("R5 wcol set", statusByte, 8'h40);
    check("R6 no irq for wcol", {7'd0, irqReq}, 8'h00);
    xferActive = 0;
    selData = 1; wrEn = 1; #0.5;
    check("R5 no inhibit idle", {7'd0, dataWrInhibit}, 8'h00);
    tick();
    check("R6 wcol kept without read", statusByte, 8'h40);
    statusRd();
    dataWr();
    check("R6 wcol cleared", statusByte, 8'h00);
  endtask

  task automatic tModeFault();
    masterEn = 1; ssDirOut = 1; ssPinLvl = 0;
    tick(); tick();
    check("R8 fault suppressed", statusByte, 8'h00);
    ssDirOut = 0;
    tick();
    check("R7 fault set", statusByte, 8'h10);
    check("R11 irq on fault", {7'd0, irqReq}, 8'h01);
    ssPinLvl = 1;
    statusRd();
    dataRd();
    check("R9 data access keeps fault", statusByte, 8'h10);
    selCtrl1 = 1; wrEn = 1; tick();
    check("R9 ctrl write clears fault", statusByte, 8'h00);
    masterEn = 0;
  endtask

  task automatic tRaces();
    pulseDone();
    statusRd();
    pulseDone();
    dataRd();
    check("R10 new event cancels pending clear", statusByte, 8'h80);
    statusRd();
    xferDone = 1; selData = 1; rdEn = 1; tick();
    check("R10 same-cycle set wins", statusByte, 8'h80);
    statusRd();
    dataRd();
    check("R10 clean clear after race", statusByte, 8'h00);
  endtask

  task automatic tIrqGate();
    irqEn = 0;
    pulseDone();
    check("R11 irq gated off", {7'd0, irqReq}, 8'h00);
    irqEn = 1; #0.5;
    check("R11 irq enabled", {7'd0, irqReq}, 8'h01);
    statusRd();
    dataRd();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tReset();
    tDoneFlag();
    tCollision();
    tModeFault();
    tRaces();
    tIrqGate();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule